// File: doc/BRIEF.md
# Programmable Delay Trigger Generator

This block produces evenly spaced single-cycle trigger pulses for a data converter. A prescaler divides the bus clock into ticks; a main counter groups the ticks into periods of a programmable length; a second, interval counter runs beside it and fires a converter trigger after every programmed number of ticks. At the end of each main period the interval counter starts over, so one main period can hold one or several converter triggers.

Software writes the period length and the interval length into holding registers; neither takes effect until a load request is raised, after which the held values are copied into the working registers at once when the counter is stopped, or at the next period end when it runs. A run begins on a start event taken from a selectable source (a software strobe or one of several hardware lines). In continuous mode the counter wraps forever; in one-shot mode it stops at the first period end and waits for a new start. A separate enable gates the trigger output without stopping the counters.

The controller has two states. `ST_IDLE` holds every counter at zero and watches the selected start source; the transition START moves it to `ST_COUNT`. In `ST_COUNT` the period end either takes the transition WRAP (continuous mode, stays in `ST_COUNT`, counters restart) or END (one-shot mode, back to `ST_IDLE`).

Top module: `pdt_trigger_gen`

## Requirements
- R1: After reset the trigger output, the running flag and the load-pending flag are all low, and no trigger appears until a start event.
- R2: The 4-bit start select picks the start source: code 15 selects the software strobe, codes 0 to 14 select hardware line of that index. Only the selected source starts a run, and only from `ST_IDLE`; start events while running are ignored.
- R3: Ticks come every (2^P)*M bus cycles, where P is the 3-bit prescale code and M is set by the 2-bit multiplier code (0:1, 1:10, 2:20, 3:40). With both codes at 0 (their reset value) a tick comes every cycle.
- R4: A main period lasts MOD ticks, MOD being the working period value (nonzero); at its last tick the main counter returns to zero.
- R5: A converter trigger is issued on every tick that completes IVL ticks since the start or since the previous trigger, IVL being the working interval value (nonzero); the interval count also restarts at every period end. The first trigger is visible IVL*(2^P)*M cycles after the cycle in which the start was sampled.
- R6: Each trigger is high for exactly one cycle when consecutive triggers are more than one cycle apart.
- R7: With the trigger enable low no trigger is issued, while the counters keep running.
- R8: In continuous mode the count restarts after every period; in one-shot mode the running flag falls after the first period end and a new start event is required.
- R9: Writes to the period and interval holding registers have no effect on trigger timing until a load request is taken.
- R10: A load request sets the load-pending flag; when stopped the values are copied and the flag cleared on the next cycle; when running the copy and clear happen at the next period end, and the new values govern the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_wr_i | input | 1 | Write strobe for the period holding register |
| ivl_wr_i | input | 1 | Write strobe for the interval holding register |
| wr_data_i | input | CNT_W | Data for holding register writes |
| load_req_i | input | 1 | Load request strobe |
| psc_sel_i | input | PSC_W | Prescale code P (divide by 2^P) |
| mult_sel_i | input | 2 | Multiplier code |
| start_sel_i | input | SEL_W | Start source select |
| sw_start_i | input | 1 | Software start strobe |
| hw_start_i | input | NUM_HW | Hardware start lines |
| cont_mode_i | input | 1 | 1: continuous, 0: one-shot |
| trig_en_i | input | 1 | Converter trigger enable |
| cnv_trig_o | output | 1 | Converter trigger pulse |
| running_o | output | 1 | High in `ST_COUNT` |
| load_pend_o | output | 1 | Load request waiting to be taken |

## Verification
The assertions take for granted that the working period and interval values are nonzero and that a load request is not raised in the same cycle as a period end that would take an earlier one. The stimulus programs only nonzero values, raises each load request as an isolated one-cycle strobe well away from period ends, and holds the prescale, multiplier, mode and select inputs steady for the whole of a run, changing them only under reset or while stopped.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } pdt_state_e;

    localparam int MULT_W = 6;

    function automatic logic [MULT_W-1:0] mult_factor(input logic [1:0] code);
        logic [MULT_W-1:0] f;
        unique case (code)
            2'd0: f = 6'd1;
            2'd1: f = 6'd10;
            2'd2: f = 6'd20;
            default: f = 6'd40;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pdt_start_sel.sv
module pdt_start_sel #(
    parameter int NUM_HW = 15,
    parameter int SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              sw_start_i,
    input  logic [NUM_HW-1:0] hw_start_i,
    output logic              start_o
);
    localparam int SRC_N   = 2 ** SEL_W;
    localparam int PAD_W   = SRC_N - NUM_HW;
    localparam logic [SEL_W-1:0] SW_CODE = SEL_W'(SRC_N - 1);

    logic [SRC_N-1:0] src_vec;

    // Hardware lines occupy the low codes; the all-ones code is software.
    always_comb begin
        src_vec = {{PAD_W{1'b0}}, hw_start_i};
        src_vec[SRC_N-1] = sw_start_i;
    end

    always_comb begin
        if (sel_i == SW_CODE) begin
            start_o = sw_start_i;
        end else begin
            start_o = src_vec[sel_i];
        end
    end

endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler
    import pdt_pkg::*;
#(
    parameter int PSC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PSC_W-1:0] psc_sel_i,
    input  logic [1:0]       mult_sel_i,
    output logic             tick_o
);
    localparam int DIV_W = MULT_W + (2 ** PSC_W) - 1;

    logic [DIV_W-1:0] div_val;
    logic [DIV_W-1:0] div_last;
    logic [DIV_W-1:0] pcnt_q;

    always_comb begin
        div_val  = DIV_W'(mult_factor(mult_sel_i)) << psc_sel_i;
        div_last = div_val - DIV_W'(1);
    end

    assign tick_o = run_i && (pcnt_q >= div_last);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pcnt_q <= '0;
        end else if (!run_i) begin
            pcnt_q <= '0;
        end else if (tick_o) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pdt_regs.sv
module pdt_regs #(
    parameter int CNT_W   = 16,
    parameter int DEF_MOD = 65535,
    parameter int DEF_IVL = 65535
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mod_wr_i,
    input  logic             ivl_wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             load_req_i,
    input  logic             load_win_i,
    output logic [CNT_W-1:0] act_mod_o,
    output logic [CNT_W-1:0] act_ivl_o,
    output logic             load_pend_o
);
    logic [CNT_W-1:0] hold_mod_q;
    logic [CNT_W-1:0] hold_ivl_q;
    logic             pend_q;
    logic             take;

    assign take        = pend_q && load_win_i;
    assign load_pend_o = pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_mod_q <= CNT_W'(DEF_MOD);
            hold_ivl_q <= CNT_W'(DEF_IVL);
        end else begin
            if (mod_wr_i) hold_mod_q <= wr_data_i;
            if (ivl_wr_i) hold_ivl_q <= wr_data_i;
        end
    end

    // R10: copy only through the load handshake
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_mod_o <= CNT_W'(DEF_MOD);
            act_ivl_o <= CNT_W'(DEF_IVL);
        end else if (take) begin
            act_mod_o <= hold_mod_q;
            act_ivl_o <= hold_ivl_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
        end else if (load_req_i) begin
            pend_q <= 1'b1;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pdt_interval.sv
module pdt_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] ivl_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] icnt_q;

    assign hit_o = tick_i && (icnt_q >= (ivl_i - CNT_W'(1)));

    // R5: restart after each trigger and at each period end
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            icnt_q <= '0;
        end else if (clr_i) begin
            icnt_q <= '0;
        end else if (tick_i) begin
            if (wrap_i || hit_o) begin
                icnt_q <= '0;
            end else begin
                icnt_q <= icnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pdt_trigger_gen.sv
module pdt_trigger_gen
    import pdt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PSC_W   = 3,
    parameter int NUM_HW  = 15,
    parameter int SEL_W   = $clog2(NUM_HW + 1),
    parameter int DEF_MOD = 65535,
    parameter int DEF_IVL = 65535
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mod_wr_i,
    input  logic              ivl_wr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              load_req_i,
    input  logic [PSC_W-1:0]  psc_sel_i,
    input  logic [1:0]        mult_sel_i,
    input  logic [SEL_W-1:0]  start_sel_i,
    input  logic              sw_start_i,
    input  logic [NUM_HW-1:0] hw_start_i,
    input  logic              cont_mode_i,
    input  logic              trig_en_i,
    output logic              cnv_trig_o,
    output logic              running_o,
    output logic              load_pend_o
);
    pdt_state_e       state_q;
    pdt_state_e       state_d;
    logic             start_evt;
    logic             tick;
    logic             last_tick;
    logic             ivl_hit;
    logic             in_count;
    logic             load_win;
    logic [CNT_W-1:0] act_mod;
    logic [CNT_W-1:0] act_ivl;
    logic [CNT_W-1:0] cnt_q;
    logic             trig_q;

    assign in_count  = (state_q == ST_COUNT);
    assign last_tick = tick && (cnt_q >= (act_mod - CNT_W'(1)));
    assign load_win  = !in_count || last_tick;

    pdt_start_sel #(
        .NUM_HW (NUM_HW),
        .SEL_W  (SEL_W)
    ) u_start (
        .sel_i      (start_sel_i),
        .sw_start_i (sw_start_i),
        .hw_start_i (hw_start_i),
        .start_o    (start_evt)
    );

    pdt_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (in_count),
        .psc_sel_i  (psc_sel_i),
        .mult_sel_i (mult_sel_i),
        .tick_o     (tick)
    );

    pdt_regs #(
        .CNT_W   (CNT_W),
        .DEF_MOD (DEF_MOD),
        .DEF_IVL (DEF_IVL)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mod_wr_i    (mod_wr_i),
        .ivl_wr_i    (ivl_wr_i),
        .wr_data_i   (wr_data_i),
        .load_req_i  (load_req_i),
        .load_win_i  (load_win),
        .act_mod_o   (act_mod),
        .act_ivl_o   (act_ivl),
        .load_pend_o (load_pend_o)
    );

    pdt_interval #(
        .CNT_W (CNT_W)
    ) u_ivl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (!in_count),
        .tick_i (tick),
        .wrap_i (last_tick),
        .ivl_i  (act_ivl),
        .hit_o  (ivl_hit)
    );

    // Next state: START, WRAP, END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_evt) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (last_tick && !cont_mode_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Main counter and registered trigger
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= in_count && ivl_hit && trig_en_i;
            if (!in_count) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= last_tick ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    assign cnv_trig_o = trig_q;
    assign running_o  = in_count;

endmodule

// File: rtl/pdt_trigger_gen_chk.sv
module pdt_trigger_gen_chk #(
    parameter int NUM_HW = 15,
    parameter int SEL_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              load_req_i,
    input logic [SEL_W-1:0]  start_sel_i,
    input logic              sw_start_i,
    input logic [NUM_HW-1:0] hw_start_i,
    input logic              cont_mode_i,
    input logic              trig_en_i,
    input logic              cnv_trig_o,
    input logic              running_o,
    input logic              load_pend_o
);
    logic any_start;
    assign any_start = sw_start_i || (|hw_start_i);

    AST_TRIG_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnv_trig_o |-> $past(trig_en_i)); // R7

    AST_TRIG_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnv_trig_o |-> $past(running_o)); // R5

    AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_o && !any_start) |=> !running_o); // R2

    AST_LDOK_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_pend_o && !running_o && !load_req_i) |=> !load_pend_o); // R10

    AST_LDOK_RISE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(load_pend_o) |-> $past(load_req_i)); // R10

    AST_ONESHOT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(running_o) |-> $past(!cont_mode_i)); // R8

    AST_START_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_o && (start_sel_i == SEL_W'(2 ** SEL_W - 1)) && !sw_start_i) |=> !running_o); // R2

endmodule

bind pdt_trigger_gen pdt_trigger_gen_chk #(
    .NUM_HW (NUM_HW),
    .SEL_W  (SEL_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_req_i  (load_req_i),
    .start_sel_i (start_sel_i),
    .sw_start_i  (sw_start_i),
    .hw_start_i  (hw_start_i),
    .cont_mode_i (cont_mode_i),
    .trig_en_i   (trig_en_i),
    .cnv_trig_o  (cnv_trig_o),
    .running_o   (running_o),
    .load_pend_o (load_pend_o)
);

// File: tb/pdt_trigger_gen_tb.sv
module pdt_trigger_gen_tb_top;

    localparam int CNT_W  = 16;
    localparam int PSC_W  = 3;
    localparam int NUM_HW = 15;
    localparam int SEL_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mod_wr = 1'b0;
    logic              ivl_wr = 1'b0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic              load_req = 1'b0;
    logic [PSC_W-1:0]  psc_sel = '0;
    logic [1:0]        mult_sel = '0;
    logic [SEL_W-1:0]  start_sel = 4'd15;
    logic              sw_start = 1'b0;
    logic [NUM_HW-1:0] hw_start = '0;
    logic              cont_mode = 1'b1;
    logic              trig_en = 1'b1;
    logic              cnv_trig;
    logic              running;
    logic              load_pend;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int pulses [0:63];
    int npul = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pdt_trigger_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .mod_wr_i    (mod_wr),
        .ivl_wr_i    (ivl_wr),
        .wr_data_i   (wr_data),
        .load_req_i  (load_req),
        .psc_sel_i   (psc_sel),
        .mult_sel_i  (mult_sel),
        .start_sel_i (start_sel),
        .sw_start_i  (sw_start),
        .hw_start_i  (hw_start),
        .cont_mode_i (cont_mode),
        .trig_en_i   (trig_en),
        .cnv_trig_o  (cnv_trig),
        .running_o   (running),
        .load_pend_o (load_pend)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cnv_trig && npul < 64) begin
            pulses[npul] = cyc;
            npul = npul + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        psc_sel = '0; mult_sel = '0; start_sel = 4'd15;
        cont_mode = 1'b1; trig_en = 1'b1; hw_start = '0; sw_start = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic write_hold(input int m, input int v);
        mod_wr = 1'b1; wr_data = CNT_W'(m);
        @(negedge clk);
        mod_wr = 1'b0; ivl_wr = 1'b1; wr_data = CNT_W'(v);
        @(negedge clk);
        ivl_wr = 1'b0;
    endtask

    task automatic program_vals(input int m, input int v);
        write_hold(m, v);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        idle(2);
    endtask

    // returns the cycle in which the start was sampled
    task automatic sw_go(output int s);
        npul = 0;
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        s = cyc;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk("R1 trig", int'(cnv_trig), 0);
        chk("R1 running", int'(running), 0);
        chk("R1 load_pend", int'(load_pend), 0);
        rst_n = 1'b1;
        npul = 0;
        idle(20);
        chk("R1 no pulse before start", npul, 0);
    endtask

    task automatic t_basic();
        int s;
        do_reset();
        write_hold(10, 10);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        chk("R10 pend set", int'(load_pend), 1);
        @(negedge clk);
        chk("R10 idle clear", int'(load_pend), 0);
        sw_go(s);
        idle(12);
        write_hold(3, 3); // R9 held only, no load request
        idle(40);
        chk("R8 continuous count", npul, 5);
        chk("R5 first", pulses[0] - s, 10);
        chk("R4 period", pulses[1] - s, 20);
        chk("R9 unchanged", pulses[2] - s, 30);
        chk("R6 width", (pulses[1] - pulses[0] > 1) ? 1 : 0, 1);
    endtask

    task automatic t_subdiv();
        int s;
        do_reset();
        program_vals(12, 5);
        sw_go(s);
        idle(26);
        chk("R5 sub a", pulses[0] - s, 5);
        chk("R5 sub b", pulses[1] - s, 10);
        chk("R5 reset at wrap", pulses[2] - s, 17);
        chk("R5 sub d", pulses[3] - s, 22);
    endtask

    task automatic t_presc();
        int s;
        do_reset();
        psc_sel = 3'd2; mult_sel = 2'd1;
        program_vals(3, 3);
        sw_go(s);
        idle(121);
        chk("R6 single cycle", int'(cnv_trig), 0);
        idle(125);
        chk("R3 first", pulses[0] - s, 120);
        chk("R3 second", pulses[1] - s, 240);
    endtask

    task automatic t_gate();
        int s;
        do_reset();
        program_vals(4, 2);
        trig_en = 1'b0;
        sw_go(s);
        idle(30);
        chk("R7 no pulse", npul, 0);
        chk("R7 still running", int'(running), 1);
    endtask

    task automatic t_oneshot();
        int s;
        do_reset();
        cont_mode = 1'b0;
        program_vals(6, 2);
        sw_go(s);
        idle(5);
        chk("R8 running", int'(running), 1);
        idle(1);
        chk("R8 stopped", int'(running), 0);
        idle(20);
        chk("R8 one period", npul, 3);
        chk("R8 last pulse", pulses[2] - s, 6);
        sw_go(s);
        idle(10);
        chk("R8 restart", npul, 3);
    endtask

    task automatic t_ldok_run();
        int s;
        do_reset();
        program_vals(10, 10);
        sw_go(s);
        while (cyc < s + 12) @(negedge clk);
        write_hold(4, 4);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        while (cyc < s + 19) @(negedge clk);
        chk("R10 pending while running", int'(load_pend), 1);
        @(negedge clk);
        chk("R10 cleared at wrap", int'(load_pend), 0);
        idle(10);
        chk("R9 old timing", pulses[1] - s, 20);
        chk("R10 new a", pulses[2] - s, 24);
        chk("R10 new b", pulses[3] - s, 28);
    endtask

    task automatic t_hw_sel();
        int s;
        do_reset();
        program_vals(4, 4);
        start_sel = 4'd3;
        npul = 0;
        hw_start[5] = 1'b1;
        @(negedge clk);
        hw_start[5] = 1'b0;
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        idle(2);
        chk("R2 other sources ignored", int'(running), 0);
        hw_start[3] = 1'b1;
        @(negedge clk);
        hw_start[3] = 1'b0;
        s = cyc;
        chk("R2 selected line starts", int'(running), 1);
        @(negedge clk);
        hw_start[3] = 1'b1;
        @(negedge clk);
        hw_start[3] = 1'b0;
        idle(10);
        chk("R2 restart ignored a", pulses[0] - s, 4);
        chk("R2 restart ignored b", pulses[1] - s, 8);
    endtask

    initial begin
        idle(2);
        t_reset();
        t_basic();
        t_subdiv();
        t_presc();
        t_gate();
        t_oneshot();
        t_ldok_run();
        t_hw_sel();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule